// File: doc/BRIEF.md
# UART Interrupt Status Masking Unit

This block keeps the eight sticky interrupt-status flags of one UART channel and produces that channel's active-low interrupt request. Event pulses come from the channel's detectors: input-pin change, receiver watchdog, address match, Xon/Xoff arrival, counter/timer expiry, break edge, and two auxiliary sources. Each pulse sets its own flag, and the flag holds until the clear action for that bit occurs. The clear actions are a read of the input port, a read of the receive FIFO, a read of the flow-control status, a counter stop, a command register code, or an auxiliary clear strobe, depending on the bit.

The CPU writes an 8-bit enable mask. A flag can pull the request low only while its mask bit is 1. A global configuration input selects what the status readback shows: the raw flags, or the flags ANDed with the mask. All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, status_o is 0x00, mask_o is 0x00 and irq_n_o is 1.
- R2: A 1 on evt_i[k] in a cycle sets status bit k at that clock edge. The bit stays set with no further pulse until its own clear action occurs.
- R3: Bit 7 (input change) clears when ipr_rd_i is 1. No other strobe clears it.
- R4: Bit 6 (receiver watchdog) clears when rxfifo_rd_i is 1. This strobe covers both the receive FIFO read and the global receive FIFO read.
- R5: Bit 5 (address match) clears only when cmd_wr_i is 1 and cmd_code_i[4:0] is 5'b11011. cmd_code_i[5] is ignored. A command write with any other low code leaves bit 5 unchanged.
- R6: Bit 4 (Xon/Xoff) clears when xisr_rd_i is 1.
- R7: Bit 3 (counter/timer) clears when ct_stop_i is 1.
- R8: Bit 2 (break change) clears when cmd_wr_i is 1 and cmd_code_i[4:0] is 5'b00101. cmd_code_i[5] is ignored.
- R9: Bit 1 clears when aux_clr_i[1] is 1. Bit 0 clears when aux_clr_i[0] is 1.
- R10: If a set pulse and a clear action for the same bit occur in the same cycle, the bit ends the cycle set.
- R11: irq_n_o is registered. It is 0 exactly one clock edge after status & mask is non-zero, and 1 one edge after it is zero. A set flag whose mask bit is 0 never drives irq_n_o low.
- R12: When mask_rd_i is 0, rd_data_o equals the status. When mask_rd_i is 1, rd_data_o equals status & mask. Both take effect in the same cycle.
- R13: When mask_wr_i is 1, mask_wdata_i is loaded into the mask at that clock edge and appears on mask_o after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Per-bit set pulses |
| ipr_rd_i | input | 1 | Input port read (clears bit 7) |
| rxfifo_rd_i | input | 1 | Receive FIFO read (clears bit 6) |
| xisr_rd_i | input | 1 | Flow-control status read (clears bit 4) |
| ct_stop_i | input | 1 | Counter stop command (clears bit 3) |
| aux_clr_i | input | 2 | Clear strobes for bits 1 and 0 |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_code_i | input | 6 | Command code |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rd_i | input | 1 | Global readback-masking select |
| status_o | output | 8 | Raw status flags |
| mask_o | output | 8 | Current mask |
| rd_data_o | output | 8 | Readback value, raw or masked |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Status flags, the raw status and the mask change at the clock edge that samples the pulse, clear or write. The checks read them at the falling edge that follows. The readback select is combinational, so its check falls in the same half cycle in which the select changes. The interrupt request comes one edge later than the flags and the mask. Its checks therefore sample once after the first edge, where the old level must still be present, and again after the second edge, where the new level is due.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 8;
  localparam int CMD_W = 6;
  localparam int AUX_W = 2;
  localparam logic [CMD_W-1:0] CMD_CARE    = 6'b01_1111;
  localparam logic [CMD_W-1:0] CMD_ADR_RST = 6'b01_1011;
  localparam logic [CMD_W-1:0] CMD_BRK_RST = 6'b00_0101;
  localparam int B_IOCHG = 7;
  localparam int B_RXWD  = 6;
  localparam int B_ADDR  = 5;
  localparam int B_XONF  = 4;
  localparam int B_CT    = 3;
  localparam int B_BRK   = 2;
endpackage

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/irq_clear_decode.sv
module irq_clear_decode
  import uart_irq_pkg::*;
(
  input  logic             ipr_rd_i,
  input  logic             rxfifo_rd_i,
  input  logic             xisr_rd_i,
  input  logic             ct_stop_i,
  input  logic [AUX_W-1:0] aux_clr_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  output logic [NSRC-1:0]  clr_o
);
  logic [CMD_W-1:0] code_cared;
  logic             adr_cmd, brk_cmd;

  assign code_cared = cmd_code_i & CMD_CARE;
  assign adr_cmd    = cmd_wr_i && (code_cared == CMD_ADR_RST);
  assign brk_cmd    = cmd_wr_i && (code_cared == CMD_BRK_RST);

  always_comb begin
    clr_o            = '0;
    clr_o[B_IOCHG]   = ipr_rd_i;
    clr_o[B_RXWD]    = rxfifo_rd_i;
    clr_o[B_ADDR]    = adr_cmd;
    clr_o[B_XONF]    = xisr_rd_i;
    clr_o[B_CT]      = ct_stop_i;
    clr_o[B_BRK]     = brk_cmd;
    clr_o[AUX_W-1:0] = aux_clr_i;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] m;

  always_ff @(posedge clk) begin
    if (!rst_n)    m <= '0;
    else if (wr_i) m <= wdata_i;
  end

  assign mask_o = m;

  assert_mask_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_o == $past(wdata_i)));
  assert_mask_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  input  logic         mask_rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         irq_n_o
);
  logic [W-1:0] live;
  logic         irq_n_q;

  assign live = status_i & mask_i;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_n_q <= 1'b1;
    else        irq_n_q <= ~|live;
  end

  assign irq_n_o   = irq_n_q;
  assign rd_data_o = mask_rd_i ? live : status_i;

  assert_irq_assert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|live) |=> !irq_n_o);
  assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |=> irq_n_o);
  assert_rd_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd_i |-> ((rd_data_o & ~mask_i) == '0));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             ipr_rd_i,
  input  logic             rxfifo_rd_i,
  input  logic             xisr_rd_i,
  input  logic             ct_stop_i,
  input  logic [AUX_W-1:0] aux_clr_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  input  logic             mask_wr_i,
  input  logic [NSRC-1:0]  mask_wdata_i,
  input  logic             mask_rd_i,
  output logic [NSRC-1:0]  status_o,
  output logic [NSRC-1:0]  mask_o,
  output logic [NSRC-1:0]  rd_data_o,
  output logic             irq_n_o
);
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] st;
  logic [NSRC-1:0] msk;

  irq_clear_decode u_dec (
    .ipr_rd_i    (ipr_rd_i),
    .rxfifo_rd_i (rxfifo_rd_i),
    .xisr_rd_i   (xisr_rd_i),
    .ct_stop_i   (ct_stop_i),
    .aux_clr_i   (aux_clr_i),
    .cmd_wr_i    (cmd_wr_i),
    .cmd_code_i  (cmd_code_i),
    .clr_o       (clr)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_i[k]),
      .clr_i (clr[k]),
      .q_o   (st[k])
    );
  end

  irq_mask_reg #(.W(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (msk)
  );

  irq_req_gen #(.W(NSRC)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (st),
    .mask_i    (msk),
    .mask_rd_i (mask_rd_i),
    .rd_data_o (rd_data_o),
    .irq_n_o   (irq_n_o)
  );

  assign status_o = st;
  assign mask_o   = msk;

  assert_addr_only_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st[B_ADDR] && !(cmd_wr_i && ((cmd_code_i & CMD_CARE) == CMD_ADR_RST)))
      |=> st[B_ADDR]);
  assert_iochg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st[B_IOCHG] && !ipr_rd_i) |=> st[B_IOCHG]);
endmodule

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       ipr_rd_i = 0, rxfifo_rd_i = 0, xisr_rd_i = 0, ct_stop_i = 0;
  logic [1:0] aux_clr_i = '0;
  logic       cmd_wr_i = 0;
  logic [5:0] cmd_code_i = '0;
  logic       mask_wr_i = 0;
  logic [7:0] mask_wdata_i = '0;
  logic       mask_rd_i = 0;
  logic [7:0] status_o, mask_o, rd_data_o;
  logic       irq_n_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ipr_rd_i(ipr_rd_i),
    .rxfifo_rd_i(rxfifo_rd_i), .xisr_rd_i(xisr_rd_i), .ct_stop_i(ct_stop_i),
    .aux_clr_i(aux_clr_i), .cmd_wr_i(cmd_wr_i), .cmd_code_i(cmd_code_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .mask_rd_i(mask_rd_i),
    .status_o(status_o), .mask_o(mask_o), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  // Vector: [39:32] req tag, [31:24] evt, [23:16] strobes
  // {ipr,rx,xisr,ct,aux1,aux0,cmdwr,0}, [15:10] cmd code, [7:0] expected status
  localparam int NV = 16;
  localparam logic [39:0] VEC [NV] = '{
    40'h02_FF_00_00_FF, // R2 set all
    40'h03_00_80_00_7F, // R3 ipr read
    40'h04_00_40_00_3F, // R4 rx fifo read
    40'h05_00_02_EC_1F, // R5 code 6'b111011
    40'h06_00_20_00_0F, // R6 xisr read
    40'h07_00_10_00_07, // R7 ct stop
    40'h08_00_02_14_03, // R8 code 6'b000101
    40'h09_00_08_00_01, // R9 aux1
    40'h09_00_04_00_00, // R9 aux0
    40'h05_20_00_00_20, // R5 set bit5
    40'h05_00_02_68_20, // R5 code 6'b011010 ignored
    40'h05_00_02_6C_00, // R5 code 6'b011011
    40'h0A_04_02_94_04, // R10 set + code 6'b100101
    40'h08_00_02_94_00, // R8 code 6'b100101
    40'h0A_40_40_00_40, // R10 set + rx read
    40'h04_00_40_00_00  // R4 clear
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_i = '0; ipr_rd_i = 0; rxfifo_rd_i = 0; xisr_rd_i = 0; ct_stop_i = 0;
    aux_clr_i = '0; cmd_wr_i = 0; cmd_code_i = '0; mask_wr_i = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n_o}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      evt_i       = v[31:24];
      ipr_rd_i    = v[23];
      rxfifo_rd_i = v[22];
      xisr_rd_i   = v[21];
      ct_stop_i   = v[20];
      aux_clr_i   = v[19:18];
      cmd_wr_i    = v[17];
      cmd_code_i  = v[15:10];
      step();
      chk($sformatf("R%0d vec%0d", v[39:32], i), status_o, v[7:0]);
    end

    // R11: flag with mask 0 leaves irq_n high
    evt_i = 8'h08; step();
    step();
    chk("R11 unmasked no irq", {7'b0, irq_n_o}, 8'h01);
    // R13: mask write
    mask_wr_i = 1; mask_wdata_i = 8'h08; step();
    chk("R13 mask_o", mask_o, 8'h08);
    chk("R11 irq not yet", {7'b0, irq_n_o}, 8'h01);
    step();
    chk("R11 irq asserted", {7'b0, irq_n_o}, 8'h00);
    // R12 readback select
    evt_i = 8'h10; step();
    chk("R12 raw", rd_data_o, 8'h18);
    mask_rd_i = 1; #1;
    chk("R12 masked", rd_data_o, 8'h08);
    mask_rd_i = 0; #1;
    chk("R12 raw again", rd_data_o, 8'h18);
    // R11 release after clear
    ct_stop_i = 1; step();
    chk("R7 ct clear", status_o, 8'h10);
    chk("R11 irq still low", {7'b0, irq_n_o}, 8'h00);
    step();
    chk("R11 irq released", {7'b0, irq_n_o}, 8'h01);
    // R3: other strobes do not clear bit 7
    evt_i = 8'h80; step();
    rxfifo_rd_i = 1; xisr_rd_i = 1; ct_stop_i = 1; aux_clr_i = 2'b11; step();
    chk("R3 bit7 kept", status_o & 8'h80, 8'h80);
    // R1 reset again
    mask_wr_i = 1; mask_wdata_i = 8'hFF; step();
    step();
    rst_n = 0; step();
    rst_n = 1;
    chk("R1 status after reset", status_o, 8'h00);
    chk("R1 mask after reset", mask_o, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_n_o}, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule